// File: doc/BRIEF.md
# Operand-Ready Warp Issue Scheduler

This block picks, every clock cycle, at most one warp from a set of resident warp slots and issues that warp's next instruction. The instruction applies to all 32 threads of the warp. A slot is resident while its `slot_valid` bit is high. An external scoreboard pulses `rdy_set` when the operands of a slot's next instruction are available. The scheduler keeps a per-slot ready flag and only considers resident slots whose flag is set.

Among eligible slots the oldest one wins. Age is the order in which slots became resident, and slots admitted in the same cycle are ordered by lower slot index. The default of 24 slots matches three resident 256-thread blocks.

Issue is registered. Selection uses only the stored ready flags, so a different warp can issue on every consecutive cycle with no idle cycle between them. The execution pipeline can hold the scheduler with `stall`. While stalled, nothing issues, and the ready flags and the age order are kept.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one warp issues per cycle: `issue_valid` is a single bit and `issue_warp` carries the binary index of the one issued slot.
- R2: A slot is eligible only while `slot_valid` is high and its ready flag is set. The flag is set by a one-cycle `rdy_set` pulse to a resident slot. A pulse to a non-resident slot has no effect.
- R3: Among eligible slots, the one that became resident earliest is issued first. A slot becomes resident in the cycle its `slot_valid` bit rises.
- R4: Slots that become resident in the same cycle are ordered lower index first.
- R5: Issuing a slot clears its ready flag, so the slot does not issue again until a later `rdy_set` pulse. A `rdy_set` pulse in the same cycle as the slot's issue is ignored.
- R6: While `stall` is high, `issue_valid` is low in the following cycle. Ready flags and the age order are unchanged by the stall.
- R7: Issue has a one-cycle registered latency. If any slot is eligible and `stall` is low, `issue_valid` is high in the next cycle. Different warps issue on consecutive cycles with no idle cycle between them.
- R8: Dropping `slot_valid` clears that slot's ready flag. A slot that becomes resident again ranks as the youngest.
- R9: While reset is high and after it, `issue_valid` is low and no ready flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | NUM_WARPS | Per-slot residency bit |
| rdy_set | input | NUM_WARPS | Per-slot operand-ready pulse from the scoreboard |
| stall | input | 1 | Execution pipeline cannot accept an instruction |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | IDX_W | Index of the issuing warp slot |

## Verification
The assertions assume that the scoreboard pulses `rdy_set` only for slots that are resident or about to be resident. They also assume that `slot_valid` changes only at clock edges, like every other input.

The stimulus drives all inputs on the falling edge. It sets ready flags only together with or after admission. It holds `stall` high while the ready flags are being loaded, so that the age order, and not arrival time, decides which warp issues first. The age comparison is only relied on between eligible slots. Those slots have been resident for at least one cycle, so their age bits are always settled.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int MAX_SLOTS = 64;

  // index of the single set bit of a one-hot vector (0 if none)
  function automatic int onehot_index(input logic [MAX_SLOTS-1:0] v);
    int r;
    r = 0;
    for (int k = 0; k < MAX_SLOTS; k++)
      if (v[k]) r = k;
    return r;
  endfunction
endpackage

// File: rtl/sched_ready_track.sv
module sched_ready_track #(
  parameter int NUM_WARPS = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] slot_valid,
  input  logic [NUM_WARPS-1:0] rdy_set,
  input  logic [NUM_WARPS-1:0] grant,
  input  logic                 fire,
  output logic [NUM_WARPS-1:0] ready_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= '0;
    end else begin
      for (int i = 0; i < NUM_WARPS; i++) begin
        if (!slot_valid[i])
          ready_q[i] <= 1'b0;
        else if (fire && grant[i])
          ready_q[i] <= 1'b0;
        else if (rdy_set[i])
          ready_q[i] <= 1'b1;
      end
    end
  end

  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fire && (|grant)) |=> ((ready_q & $past(grant)) == '0)); // R5
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ready_q & ~$past(slot_valid)) == '0)); // R8
endmodule

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
  parameter int NUM_WARPS = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] slot_valid,
  input  logic [NUM_WARPS-1:0] elig,
  output logic [NUM_WARPS-1:0] grant
);
  logic [NUM_WARPS-1:0] valid_q;
  logic [NUM_WARPS-1:0] admit;
  // older_q[i][j] : slot i became resident before slot j
  logic [NUM_WARPS-1:0] older_q [NUM_WARPS];

  assign admit = slot_valid & ~valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_WARPS; i++) older_q[i] <= '0;
    end else begin
      valid_q <= slot_valid;
      for (int i = 0; i < NUM_WARPS; i++) begin
        for (int j = 0; j < NUM_WARPS; j++) begin
          if (admit[i])
            older_q[i][j] <= admit[j] ? (i < j) : 1'b0;
          else if (admit[j])
            older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_WARPS; i++) begin
      grant[i] = elig[i];
      for (int j = 0; j < NUM_WARPS; j++)
        if (j != i && elig[j] && !older_q[i][j]) grant[i] = 1'b0;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R1
  AST_GRANT_WHEN_ELIG: assert property (@(posedge clk) disable iff (rst)
    (|elig) |-> (|grant)); // R7

  for (genvar a = 0; a < NUM_WARPS; a++) begin : g_row
    for (genvar b = a + 1; b < NUM_WARPS; b++) begin : g_col
      AST_AGE_ORDERED: assert property (@(posedge clk) disable iff (rst)
        (elig[a] && elig[b]) |-> (older_q[a][b] != older_q[b][a])); // R3
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 24,
  localparam int IDX_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] slot_valid,
  input  logic [NUM_WARPS-1:0] rdy_set,
  input  logic                 stall,
  output logic                 issue_valid,
  output logic [IDX_W-1:0]     issue_warp
);
  import wis_pkg::*;

  logic [NUM_WARPS-1:0] ready_q;
  logic [NUM_WARPS-1:0] elig;
  logic [NUM_WARPS-1:0] grant;
  logic                 fire;
  logic [MAX_SLOTS-1:0] grant_wide;

  assign elig       = slot_valid & ready_q;
  assign fire       = !stall;
  assign grant_wide = MAX_SLOTS'(grant);

  sched_ready_track #(.NUM_WARPS(NUM_WARPS)) u_ready (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .rdy_set(rdy_set),
    .grant(grant), .fire(fire), .ready_q(ready_q)
  );

  sched_age_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .elig(elig), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
    end else begin
      issue_valid <= fire && (|grant);
      if (fire && (|grant))
        issue_warp <= IDX_W'(onehot_index(grant_wide));
    end
  end

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall |=> !issue_valid); // R6
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (!stall && (|elig)) |=> issue_valid); // R7
  AST_ISSUE_RESIDENT: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (($past(slot_valid) >> issue_warp) & 1) != 0); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !issue_valid); // R9
endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int N = 24;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  slot_valid = '0;
  logic [N-1:0]  rdy_set = '0;
  logic          stall = 1'b0;
  logic          issue_valid;
  logic [IW-1:0] issue_warp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N)) uut (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .rdy_set(rdy_set),
    .stall(stall), .issue_valid(issue_valid), .issue_warp(issue_warp)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  // expect (v, w) on the issue outputs at the current falling edge
  task automatic expect_issue(input logic v, input int w, input string tag);
    checks++;
    if (issue_valid !== v || (v && int'(issue_warp) != w)) begin
      errors++;
      $display("FAIL %s: got valid=%0b warp=%0d, expected valid=%0b warp=%0d",
               tag, issue_valid, issue_warp, v, w);
    end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    expect_issue(1'b0, 0, "R9 idle in reset");
    rst = 1'b0;
    tick();
    expect_issue(1'b0, 0, "R9 idle after reset");
  endtask

  // staggered admission, stall while loading, then back-to-back issue
  task automatic t_oldest_first();
    stall = 1'b1;
    slot_valid[5] = 1'b1; rdy_set = '0; rdy_set[5] = 1'b1; tick();
    slot_valid[2] = 1'b1; rdy_set = '0; rdy_set[2] = 1'b1; tick();
    slot_valid[9] = 1'b1; rdy_set = '0; rdy_set[9] = 1'b1; tick();
    rdy_set = '0; tick();
    expect_issue(1'b0, 0, "R6 stalled, nothing issues");
    stall = 1'b0; tick();
    expect_issue(1'b1, 5, "R3 oldest slot 5 first");
    tick();
    expect_issue(1'b1, 2, "R7 back-to-back slot 2");
    tick();
    expect_issue(1'b1, 9, "R7 back-to-back slot 9");
    tick();
    expect_issue(1'b0, 0, "R5 no reissue without new ready");
  endtask

  task automatic t_same_cycle_admit();
    slot_valid = '0; tick();
    tick();
    expect_issue(1'b0, 0, "R8 dropped slots idle");
    stall = 1'b1;
    slot_valid[7] = 1'b1; slot_valid[3] = 1'b1;
    rdy_set = '0; rdy_set[7] = 1'b1; rdy_set[3] = 1'b1; tick();
    rdy_set = '0; stall = 1'b0; tick();
    expect_issue(1'b1, 3, "R4 lower index first on tie");
    tick();
    expect_issue(1'b1, 7, "R4 then slot 7");
    tick();
    expect_issue(1'b0, 0, "R5 idle after both issued");
  endtask

  task automatic t_set_during_issue();
    rdy_set = '0; rdy_set[7] = 1'b1; tick();
    // slot 7 is selected this cycle; a new pulse now must be ignored
    rdy_set = '0; rdy_set[7] = 1'b1; tick();
    rdy_set = '0;
    expect_issue(1'b1, 7, "R5 slot 7 issues once");
    tick();
    expect_issue(1'b0, 0, "R5 pulse during issue ignored");
  endtask

  task automatic t_stall_hold();
    stall = 1'b1;
    rdy_set = '0; rdy_set[7] = 1'b1; rdy_set[3] = 1'b1; tick();
    rdy_set = '0;
    for (int k = 0; k < 3; k++) begin
      tick();
      expect_issue(1'b0, 0, "R6 stall holds issue");
    end
    stall = 1'b0; tick();
    expect_issue(1'b1, 3, "R6 order kept after stall");
    tick();
    expect_issue(1'b1, 7, "R6 ready kept after stall");
    tick();
  endtask

  task automatic t_nonresident();
    rdy_set = '0; rdy_set[10] = 1'b1; tick();
    rdy_set = '0; tick();
    expect_issue(1'b0, 0, "R2 ready to empty slot ignored");
    slot_valid[10] = 1'b1; tick();
    tick();
    expect_issue(1'b0, 0, "R2 resident but not ready");
    // ready then dropped before issue
    stall = 1'b1; rdy_set[10] = 1'b1; tick();
    rdy_set = '0; slot_valid[10] = 1'b0; tick();
    slot_valid[10] = 1'b1; stall = 1'b0; tick();
    tick();
    expect_issue(1'b0, 0, "R8 drop clears ready");
  endtask

  task automatic t_readmit_youngest();
    // resident: 3 (oldest), 7, 10 (youngest)
    slot_valid[3] = 1'b0; tick();
    slot_valid[3] = 1'b1; tick();
    stall = 1'b1;
    rdy_set = '0; rdy_set[3] = 1'b1; rdy_set[7] = 1'b1; rdy_set[10] = 1'b1; tick();
    rdy_set = '0; stall = 1'b0; tick();
    expect_issue(1'b1, 7, "R8 readmitted slot ranks last (7)");
    tick();
    expect_issue(1'b1, 10, "R3 slot 10 next");
    tick();
    expect_issue(1'b1, 3, "R8 readmitted slot 3 last");
    tick();
    expect_issue(1'b0, 0, "R1 idle after drain");
  endtask

  initial begin
    t_reset();
    t_oldest_first();
    t_same_cycle_admit();
    t_set_during_issue();
    t_stall_hold();
    t_nonresident();
    t_readmit_youngest();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule